// File: doc/BRIEF.md
# Configurable Serial Character Receiver with Line Status

This block turns an asynchronous serial line into whole characters. A six-bit frame control word sets the number of data bits (five to eight), the stop-bit length, and the parity mode: none, odd, even, forced-one (mark) or forced-zero (space). A single-cycle enable tick, pulsed at sixteen times the bit rate, paces all sampling. The line is first passed through a synchroniser. A low level is then confirmed at the middle of the start bit, and each later bit is sampled at its own middle. Bits arrive least significant first.

The finished character goes into a one-deep holding buffer. A status byte reports five conditions: a character is waiting, overrun, parity error, framing error, and line break. The host reads the buffer with a data-read strobe and clears the error flags with a status-read strobe. An interrupt request is raised while any error or overrun flag is set.

The receive state machine has these states: IDLE (wait for a low sample on a tick), START (count to mid start bit; the low level confirmed there leads to DATA, a high level returns to IDLE), DATA (one mid-bit sample per bit; after the last bit go to PARITY if parity is on, otherwise STOP1), PARITY (sample and compare, then STOP1), STOP1 (an all-zero frame ending in a low stop leads to BRKWAIT; otherwise a second stop leads to STOP2; otherwise the character is delivered and the machine returns to IDLE), STOP2 (sample the extra stop, deliver, go to IDLE) and BRKWAIT (deliver nothing more until a tick sees the line high, then go to IDLE).

Top module: `uart_rx_line`

## Requirements
- R1: Frame control bits [1:0] select the data length: 00 five bits, 01 six, 10 seven, 11 eight. Bits are received least significant first. The character is right-aligned on the data output with unused upper bits zero.
- R2: Frame control bits [5:3] select parity: 000 none, 001 odd, 011 even, 101 mark (parity bit must be 1), 111 space (must be 0). Any other code with bit 3 clear means none. A mismatch sets status bit 2.
- R3: Frame control bit 2 clear gives one stop bit. Set, it gives two stop bits, or one and a half when the length is five. A low level at any checked stop position sets status bit 3.
- R4: A low pulse that has returned high by the middle of the start bit (sample 8 of 16) is discarded. No character is delivered.
- R5: Status bit 0 sets when a character is loaded into the buffer and clears on a data-read strobe. A load in the same cycle keeps it set.
- R6: Status bit 1 sets when a character is loaded while bit 0 is still set and no data read happens in that cycle. The buffer then holds the newer character.
- R7: If the start bit, all data bits, any parity bit and the first stop bit are all low, status bit 4 sets and one all-zero character is loaded with bits 2 and 3 left clear. No further character is taken until a tick sees the line high.
- R8: A status-read strobe clears status bits 1 to 4 on the clock edge that ends the strobe cycle. During that cycle the output shows their values. Bit 0 is not affected.
- R9: The interrupt output is high exactly when any of status bits 1 to 4 is set.
- R10: The frame control word is captured when the start bit is confirmed. Changes during a character do not affect that character.
- R11: After reset the status byte is 00, the data output is 00, the interrupt is low, and status bits 7 to 5 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Sampling enable, one cycle wide, 16 per bit time |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| line_ctrl_i | input | 6 | Frame control: [1:0] length, [2] stop, [5:3] parity |
| rd_data_i | input | 1 | Buffer read strobe |
| rd_status_i | input | 1 | Status read strobe |
| status_o | output | 8 | {000, break, framing, parity, overrun, data ready} |
| data_o | output | 8 | Receive buffer |
| irq_o | output | 1 | Error or overrun interrupt request |

## Verification
The hardest conditions to reach from the ports are a break and a stop bit that goes bad just after a valid stop. A bad stop can leave the line low right where the receiver is hunting for a new start bit, so a badly timed stimulus would create a false character. The bench therefore drives a bad stop low for only three quarters of the bit, which places the line high before any spurious start could be confirmed. It reaches a break in two ways: by holding the line low for many character times, and through random all-zero data that meets a bad first stop. Random frames with a fixed seed cover every length, stop and parity combination.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_BRKWAIT
    } rx_state_e;

    // field order follows the control word bit positions [5:0]
    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len;
    } frame_cfg_t;

    // expected parity bit for right-aligned data
    function automatic logic want_parity(frame_cfg_t c, logic [CHAR_W-1:0] d);
        logic x;
        x = ^d;
        if (c.stick) return ~c.even;
        return c.even ? x : ~x;
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  frame_cfg_t        cfg_i,
    output logic              ld_valid_o,
    output logic [CHAR_W-1:0] ld_data_o,
    output logic              ld_pe_o,
    output logic              ld_fe_o,
    output logic              ld_brk_o
);
    localparam int CNT_W     = $clog2(OSR);
    localparam int MID       = OSR / 2 - 1;
    localparam int LAST      = OSR - 1;
    localparam int HALF_STOP = OSR / 2 + OSR / 4 - 1;

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  tcnt_q, target;
    logic [2:0]        bitcnt_q, last_idx;
    logic [CHAR_W-1:0] shreg_q, aligned;
    frame_cfg_t        cfg_q;
    logic              zero_q, pe_q, fe_q, hit;

    always_comb begin
        if (state_q == ST_START)
            target = CNT_W'(MID);
        else if (state_q == ST_STOP2 && cfg_q.len == 2'd0)
            target = CNT_W'(HALF_STOP);
        else
            target = CNT_W'(LAST);
        hit      = tick_i && (tcnt_q == target);
        last_idx = 3'd4 + {1'b0, cfg_q.len};
        aligned  = shreg_q >> (3'd3 - {1'b0, cfg_q.len});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tick_i && !rx_i) state_d = ST_START;
            ST_START:   if (hit) state_d = rx_i ? ST_IDLE : ST_DATA;
            ST_DATA:    if (hit && bitcnt_q == last_idx)
                            state_d = cfg_q.par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY:  if (hit) state_d = ST_STOP1;
            ST_STOP1:   if (hit) begin
                            if (zero_q && !rx_i)  state_d = ST_BRKWAIT;
                            else if (cfg_q.two_stop) state_d = ST_STOP2;
                            else                  state_d = ST_IDLE;
                        end
            ST_STOP2:   if (hit) state_d = ST_IDLE;
            ST_BRKWAIT: if (tick_i && rx_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q     <= '0;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            cfg_q      <= '0;
            zero_q     <= 1'b0;
            pe_q       <= 1'b0;
            fe_q       <= 1'b0;
            ld_valid_o <= 1'b0;
            ld_data_o  <= '0;
            ld_pe_o    <= 1'b0;
            ld_fe_o    <= 1'b0;
            ld_brk_o   <= 1'b0;
        end else begin
            ld_valid_o <= 1'b0;
            if (state_q == ST_IDLE || state_q == ST_BRKWAIT)
                tcnt_q <= '0;
            else if (tick_i)
                tcnt_q <= hit ? '0 : tcnt_q + 1'b1;
            unique case (state_q)
                ST_START: if (hit && !rx_i) begin
                    bitcnt_q <= '0;
                    zero_q   <= 1'b1;
                    pe_q     <= 1'b0;
                    fe_q     <= 1'b0;
                    cfg_q    <= cfg_i;
                end
                ST_DATA: if (hit) begin
                    shreg_q  <= {rx_i, shreg_q[CHAR_W-1:1]};
                    zero_q   <= zero_q & ~rx_i;
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
                ST_PARITY: if (hit) begin
                    pe_q   <= rx_i ^ want_parity(cfg_q, aligned);
                    zero_q <= zero_q & ~rx_i;
                end
                ST_STOP1: if (hit) begin
                    if (zero_q && !rx_i) begin
                        ld_valid_o <= 1'b1;
                        ld_data_o  <= '0;
                        ld_pe_o    <= 1'b0;
                        ld_fe_o    <= 1'b0;
                        ld_brk_o   <= 1'b1;
                    end else if (cfg_q.two_stop) begin
                        fe_q <= ~rx_i;
                    end else begin
                        ld_valid_o <= 1'b1;
                        ld_data_o  <= aligned;
                        ld_pe_o    <= pe_q;
                        ld_fe_o    <= ~rx_i;
                        ld_brk_o   <= 1'b0;
                    end
                end
                ST_STOP2: if (hit) begin
                    ld_valid_o <= 1'b1;
                    ld_data_o  <= aligned;
                    ld_pe_o    <= pe_q;
                    ld_fe_o    <= fe_q | ~rx_i;
                    ld_brk_o   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid_i,
    input  logic [CHAR_W-1:0] ld_data_i,
    input  logic              ld_pe_i,
    input  logic              ld_fe_i,
    input  logic              ld_brk_i,
    input  logic              rd_data_i,
    input  logic              rd_status_i,
    output logic [7:0]        status_o,
    output logic [CHAR_W-1:0] data_o,
    output logic              irq_o
);
    logic dr_q, oe_q, pe_q, fe_q, bi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q   <= 1'b0;
            oe_q   <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            bi_q   <= 1'b0;
            data_o <= '0;
        end else begin
            if (ld_valid_i)     dr_q <= 1'b1;
            else if (rd_data_i) dr_q <= 1'b0;

            if (ld_valid_i && dr_q && !rd_data_i) oe_q <= 1'b1;
            else if (rd_status_i)                 oe_q <= 1'b0;

            if (ld_valid_i && ld_pe_i)  pe_q <= 1'b1;
            else if (rd_status_i)       pe_q <= 1'b0;

            if (ld_valid_i && ld_fe_i)  fe_q <= 1'b1;
            else if (rd_status_i)       fe_q <= 1'b0;

            if (ld_valid_i && ld_brk_i) bi_q <= 1'b1;
            else if (rd_status_i)       bi_q <= 1'b0;

            if (ld_valid_i) data_o <= ld_data_i;
        end
    end

    assign status_o = {3'b000, bi_q, fe_q, pe_q, oe_q, dr_q};
    assign irq_o    = oe_q | pe_q | fe_q | bi_q;

endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick_i,
    input  logic       rx_i,
    input  logic [5:0] line_ctrl_i,
    input  logic       rd_data_i,
    input  logic       rd_status_i,
    output logic [7:0] status_o,
    output logic [7:0] data_o,
    output logic       irq_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    frame_cfg_t             cfg_w;
    logic                   ld_valid, ld_pe, ld_fe, ld_brk;
    logic [CHAR_W-1:0]      ld_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end

    assign rx_s  = sync_q[SYNC_STAGES-1];
    assign cfg_w = frame_cfg_t'(line_ctrl_i);

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (os_tick_i),
        .rx_i       (rx_s),
        .cfg_i      (cfg_w),
        .ld_valid_o (ld_valid),
        .ld_data_o  (ld_data),
        .ld_pe_o    (ld_pe),
        .ld_fe_o    (ld_fe),
        .ld_brk_o   (ld_brk)
    );

    uart_rx_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid_i  (ld_valid),
        .ld_data_i   (ld_data),
        .ld_pe_i     (ld_pe),
        .ld_fe_i     (ld_fe),
        .ld_brk_i    (ld_brk),
        .rd_data_i   (rd_data_i),
        .rd_status_i (rd_status_i),
        .status_o    (status_o),
        .data_o      (data_o),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/uart_rx_line_chk.sv
module uart_rx_line_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_data_i,
    input logic       rd_status_i,
    input logic       ld_valid,
    input logic       ld_brk,
    input logic [7:0] ld_data,
    input logic [7:0] status_o
);
    // R5
    dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> status_o[0]);

    // R5
    dr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_i && !ld_valid |=> !status_o[0]);

    // R6
    oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && status_o[0] && !rd_data_i |=> status_o[1]);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status_i && !ld_valid |=> status_o[4:1] == 4'd0);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_status_i && status_o[4:1] != 4'd0
        |=> (status_o[4:1] & $past(status_o[4:1])) == $past(status_o[4:1]));

    // R7
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && ld_brk |-> ld_data == 8'd0);
endmodule

bind uart_rx_line uart_rx_line_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data_i   (rd_data_i),
    .rd_status_i (rd_status_i),
    .ld_valid    (ld_valid),
    .ld_brk      (ld_brk),
    .ld_data     (ld_data),
    .status_o    (status_o)
);

// File: tb/uart_rx_line_tb.sv
`timescale 1ns/1ps
module uart_rx_line_tb;
    localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [5:0] lc = 6'h03;
    logic       rd_data = 1'b0, rd_status = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       tick;
    logic [7:0] status_o, data_o;
    logic       irq_o;
    int         n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd0);

    uart_rx_line u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick_i(tick), .rx_i(rx),
        .line_ctrl_i(lc), .rd_data_i(rd_data), .rd_status_i(rd_status),
        .status_o(status_o), .data_o(data_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] len_mask(input logic [5:0] c);
        return 8'hFF >> (3 - c[1:0]);
    endfunction

    function automatic logic par_of(input logic [5:0] c, input logic [7:0] d);
        logic x;
        x = ^(d & len_mask(c));
        case (c[5:3])
            3'b001: return ~x;
            3'b011: return x;
            3'b101: return 1'b1;
            3'b111: return 1'b0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [5:0] c, input logic [5:0] c_mid,
                             input logic [7:0] d, input logic flip,
                             input logic bad1, input logic bad2);
        lc = c;
        hold(1'b0, BIT_CLK);
        lc = c_mid;
        for (int k = 0; k < 5 + c[1:0]; k++) hold(d[k], BIT_CLK);
        if (c[3]) hold(par_of(c, d) ^ flip, BIT_CLK);
        if (bad1) begin hold(1'b0, 48); hold(1'b1, 16); end
        else hold(1'b1, BIT_CLK);
        if (c[2]) begin
            if (c[1:0] == 2'd0) hold(!bad2, 32);
            else if (bad2) begin hold(1'b0, 48); hold(1'b1, 16); end
            else hold(1'b1, BIT_CLK);
        end
        hold(1'b1, 2 * BIT_CLK);
    endtask

    task automatic read_all(input string req, input logic [7:0] es, input logic [7:0] ed);
        chk(req, status_o, es);
        chk({req, " R9"}, {7'd0, irq_o}, {7'd0, |es[4:1]});
        chk(req, data_o, ed);
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
        chk("R8 clear on status read", status_o, es & 8'h01);
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
        chk("R5 clear on data read", status_o, 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] c;
        logic [7:0] d, es;
        logic flip, b1, b2, brk, pb;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 status", status_o, 8'h00);
        chk("R11 data", data_o, 8'h00);
        chk("R11 irq", {7'd0, irq_o}, 8'h00);

        // R4 short glitch rejected
        hold(1'b0, 12); hold(1'b1, 3 * BIT_CLK);
        chk("R4 glitch", status_o, 8'h00);

        // R1 directed: 5 bits, LSB first, upper zero
        send_char(6'h00, 6'h00, 8'hF3, 1'b0, 1'b0, 1'b0);
        read_all("R1 five bits", 8'h01, 8'h13);

        // R2 mark parity wrong, space parity right
        send_char(6'h2A, 6'h2A, 8'h55, 1'b1, 1'b0, 1'b0);
        read_all("R2 mark", 8'h05, 8'h55);
        send_char(6'h3B, 6'h3B, 8'hA5, 1'b0, 1'b0, 1'b0);
        read_all("R2 space", 8'h01, 8'hA5);

        // R3 bad half stop (5 bits, 1.5 stop), bad second stop (8 bits)
        send_char(6'h04, 6'h04, 8'h0A, 1'b0, 1'b0, 1'b1);
        read_all("R3 half stop", 8'h09, 8'h0A);
        send_char(6'h07, 6'h07, 8'h81, 1'b0, 1'b0, 1'b1);
        read_all("R3 second stop", 8'h09, 8'h81);

        // R10 control change mid-character ignored
        send_char(6'h03, 6'h1C, 8'hC6, 1'b0, 1'b0, 1'b0);
        read_all("R10 latched control", 8'h01, 8'hC6);

        // R6 overrun keeps the newer character
        send_char(6'h03, 6'h03, 8'h11, 1'b0, 1'b0, 1'b0);
        send_char(6'h03, 6'h03, 8'h22, 1'b0, 1'b0, 1'b0);
        read_all("R6 overrun", 8'h03, 8'h22);

        // R7 long break: one zero character, then silence
        lc = 6'h03;
        hold(1'b0, 14 * BIT_CLK);
        hold(1'b1, 2 * BIT_CLK);
        read_all("R7 break", 8'h11, 8'h00);
        hold(1'b1, 2 * BIT_CLK);
        chk("R7 single char", status_o, 8'h00);

        // random frames: R1 R2 R3 R5 R7
        for (int i = 0; i < 40; i++) begin
            case ($urandom % 5)
                0: c = 6'h00; 1: c = 6'h08; 2: c = 6'h18; 3: c = 6'h28;
                default: c = 6'h38;
            endcase
            c[2]   = 1'($urandom % 2);
            c[1:0] = 2'($urandom % 4);
            d    = 8'($urandom) & len_mask(c);
            if (i % 7 == 3) d = 8'h00;
            flip = c[3] && ($urandom % 4 == 0);
            b1   = ($urandom % 5 == 0) || (i % 7 == 3);
            b2   = c[2] && ($urandom % 5 == 0);
            pb   = par_of(c, d) ^ flip;
            brk  = (d == 8'h00) && (!c[3] || !pb) && b1;
            if (brk) b2 = 1'b0;
            send_char(c, c, d, flip, b1, b2);
            es = 8'h01;
            if (brk) es[4] = 1'b1;
            if (!brk && c[3] && flip) es[2] = 1'b1;
            if (!brk && (b1 || b2)) es[3] = 1'b1;
            read_all("R1 R2 R3 R7 random", es, d);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule